// File: doc/BRIEF.md
# Time-Slot Bit-Mask Data Link Tap

This block taps a low-rate data link out of a framed serial stream, and can put one back into it. Each cycle with `bit_en` high presents one line bit, tagged with its time slot number, its position inside the slot and a flag that marks the frame's framing bit. Software picks one slot with `sel_slot` and an 8-bit `mask` that enables any subset of that slot's bit positions. Only those positions carry link bits. Setting `sel_fbit` moves the link onto the framing bits instead, and the mask then plays no part.

Received link bits are gathered into bytes of 8 bits, or of 6 bits when `pack6` is set. Each finished byte is shown on `rx_byte` with a one-cycle `rx_valid` pulse. On the transmit side, link bits are taken one at a time from `tx_byte`, starting at bit 0. Every other line bit passes through from `tx_line_in` to `tx_line_out` unchanged. `tx_take` tells the byte source that the current byte has been used up. There is no protocol processing: every link bit passes in both directions as it is.

Top module: `dl_slot_tap`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rx_valid` is 0 and `rx_byte` is 0x00. The first link bit after reset is byte bit 0.
- R2: With `sel_fbit` low, a line bit is a link bit only when all of the following hold: `bit_en` is 1, `fbit` is 0, `slot_idx` equals `sel_slot`, and `mask[bit_pos]` is 1. `bit_pos` 0 is the first bit of the slot and `bit_pos` 7 is the eighth.
- R3: With `sel_fbit` high, every line bit with `bit_en` and `fbit` both high is a link bit, whatever `mask` holds. No other line bit is a link bit.
- R4: With `pack6` low, every 8 link bits form one byte. The first bit lands in bit 0 and the eighth in bit 7. The byte appears on `rx_byte`, with `rx_valid` high, in the cycle after the eighth link bit.
- R5: With `pack6` high, every 6 link bits form one byte. They fill bits 5:0, first bit in bit 0, and bits 7:6 read 0. The byte appears in the cycle after the sixth link bit.
- R6: A partly filled byte carries over across slots, frames and idle cycles. `rx_valid` is high only in the cycle after a byte completes.
- R7: In a link-bit cycle, `tx_line_out` equals `tx_byte[k]`, where k counts the link bits since the last byte boundary (0 after reset). In any other cycle, `tx_line_out` equals `tx_line_in`.
- R8: `tx_take` is high in exactly those cycles that carry the last link bit of a byte (the 8th, or the 6th with `pack6`). The source then moves on to its next byte at that clock edge.
- R9: `rx_byte` keeps its value in every cycle in which `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | A line bit is present this cycle |
| slot_idx | input | SLOT_W | Time slot number of the current bit |
| bit_pos | input | 3 | Position of the current bit within its slot, 0 first |
| fbit | input | 1 | Current bit is the framing bit |
| sel_slot | input | SLOT_W | Slot that carries the link |
| sel_fbit | input | 1 | Use the framing bits as the link |
| mask | input | 8 | Enabled bit positions within the selected slot |
| pack6 | input | 1 | 6 link bits per byte instead of 8 |
| rx_bit | input | 1 | Received line bit |
| rx_byte | output | 8 | Last completed receive byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_byte` was just updated |
| tx_line_in | input | 1 | Transmit line bit before insertion |
| tx_byte | input | 8 | Current byte to transmit |
| tx_line_out | output | 1 | Transmit line bit after insertion |
| tx_take | output | 1 | Last link bit of `tx_byte` is used this cycle |

## Verification
The assertions assume that `pack6`, `sel_fbit`, `sel_slot` and `mask` change only while reset is held, so a byte never changes length or source in the middle. The bench follows this by pulsing reset before each new configuration. They also assume that `fbit` and a slot bit never arrive in the same cycle. The stimulus walks whole frames: one framing bit, then eight positions in each slot, with random idle cycles in between. `tx_byte` is always driven from the bench's own byte queue, and the queue moves on only at the edge where `tx_take` is expected.

// File: rtl/dl_slot_tap.sv
module dl_slot_tap #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [2:0]        bit_pos,
  input  logic              fbit,
  input  logic [SLOT_W-1:0] sel_slot,
  input  logic              sel_fbit,
  input  logic [7:0]        mask,
  input  logic              pack6,
  input  logic              rx_bit,
  output logic [7:0]        rx_byte,
  output logic              rx_valid,
  input  logic              tx_line_in,
  input  logic [7:0]        tx_byte,
  output logic              tx_line_out,
  output logic              tx_take
);
  logic [2:0] cnt;
  logic [7:0] acc;
  logic       slot_hit, link, wrap;
  logic [2:0] last;

  assign slot_hit = !fbit && (slot_idx == sel_slot) && mask[bit_pos];
  assign link     = bit_en && (sel_fbit ? fbit : slot_hit);
  assign last     = pack6 ? 3'd5 : 3'd7;
  assign wrap     = link && (cnt == last);

  assign tx_line_out = link ? tx_byte[cnt] : tx_line_in;
  assign tx_take     = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      acc      <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= wrap;
      if (link) begin
        acc[cnt] <= rx_bit;
        cnt      <= wrap ? 3'd0 : cnt + 3'd1;
      end
      if (wrap)
        rx_byte <= pack6 ? {2'b00, rx_bit, acc[4:0]} : {rx_bit, acc[6:0]};
    end
  end
endmodule

// File: rtl/dl_slot_tap_chk.sv
module dl_slot_tap_chk #(
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [2:0]        bit_pos,
  input logic              fbit,
  input logic [SLOT_W-1:0] sel_slot,
  input logic              sel_fbit,
  input logic [7:0]        mask,
  input logic              pack6,
  input logic              tx_line_in,
  input logic [7:0]        rx_byte,
  input logic              rx_valid,
  input logic              tx_line_out,
  input logic              tx_take
);
  a_r2_masked_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !sel_fbit && !fbit && slot_idx == sel_slot && !mask[bit_pos])
      |-> (tx_line_out == tx_line_in && !tx_take));

  a_r2_other_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_fbit && slot_idx != sel_slot) |-> (tx_line_out == tx_line_in && !tx_take));

  a_r3_payload_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fbit && !fbit) |-> (tx_line_out == tx_line_in && !tx_take));

  a_r8_take_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> bit_en);

  a_r4_valid_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> rx_valid);

  a_r6_valid_only_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tx_take));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pack6) |-> rx_byte[7:6] == 2'b00);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte));
endmodule

bind dl_slot_tap dl_slot_tap_chk #(.SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/dl_slot_tap_bench.sv
module dl_slot_tap_bench;
  localparam int SLOT_W = 5;
  localparam int NSLOT  = 24;

  logic clk = 0;
  logic rst_n = 0;
  logic bit_en = 0, fbit = 0, sel_fbit = 0, pack6 = 0, rx_bit = 0, tx_line_in = 0;
  logic [SLOT_W-1:0] slot_idx = '0, sel_slot = '0;
  logic [2:0] bit_pos = '0;
  logic [7:0] mask = '0, tx_byte = '0;
  logic [7:0] rx_byte;
  logic rx_valid, tx_line_out, tx_take;

  always #5 clk = ~clk;

  dl_slot_tap #(.SLOT_W(SLOT_W)) u_dl_slot_tap (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  int m_cnt;
  bit m_bits[8];
  logic [7:0] m_byte;
  bit m_valid;
  logic [7:0] txq[$];
  logic [7:0] tx_cur;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_byte = 0; m_valid = 0;
    txq.delete();
    for (int i = 0; i < 64; i++) txq.push_back(8'($urandom));
    tx_cur = txq.pop_front();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_en = 0;
    repeat (2) @(negedge clk);
    model_reset();
    tx_byte = tx_cur;
    chk("R1 valid in reset", {7'd0, rx_valid}, 8'd0);
    chk("R1 byte in reset", rx_byte, 8'd0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 valid after reset", {7'd0, rx_valid}, 8'd0);
    chk("R1 byte after reset", rx_byte, 8'd0);
  endtask

  task automatic step(bit en, bit fb, int slot, int pos);
    bit link, lastb;
    int last;
    @(negedge clk);
    bit_en = en; fbit = fb; slot_idx = SLOT_W'(slot); bit_pos = 3'(pos);
    rx_bit = 1'($urandom); tx_line_in = 1'($urandom);
    tx_byte = tx_cur;
    #1;
    if (sel_fbit) link = en && fb;
    else link = en && !fb && (slot == int'(sel_slot)) && mask[pos];
    last = pack6 ? 5 : 7;
    lastb = link && (m_cnt == last);
    chk(sel_fbit ? "R3 tx_line_out" : "R2/R7 tx_line_out",
        {7'd0, tx_line_out}, {7'd0, link ? tx_cur[m_cnt] : tx_line_in});
    chk("R8 tx_take", {7'd0, tx_take}, {7'd0, lastb});
    m_valid = 0;
    if (link) begin
      m_bits[m_cnt] = rx_bit;
      if (lastb) begin
        m_byte = 0;
        for (int i = 0; i <= last; i++) m_byte[i] = m_bits[i];
        m_valid = 1;
        m_cnt = 0;
        if (txq.size() == 0) txq.push_back(8'($urandom));
        tx_cur = txq.pop_front();
      end else m_cnt++;
    end
    @(posedge clk); #1;
    chk("R6 rx_valid", {7'd0, rx_valid}, {7'd0, m_valid});
    chk(m_valid ? (pack6 ? "R5 rx_byte" : "R4 rx_byte") : "R9 rx_byte hold", rx_byte, m_byte);
  endtask

  task automatic run_frames(int n);
    for (int f = 0; f < n; f++) begin
      step(1, 1, 0, 0);
      for (int s = 0; s < NSLOT; s++)
        for (int b = 0; b < 8; b++) begin
          if ($urandom_range(0, 9) == 0) step(0, 0, s, b);
          step(1, 0, s, b);
        end
    end
  endtask

  task automatic config_run(bit fsel, int slot, logic [7:0] m, bit p6, int frames);
    sel_fbit = fsel; sel_slot = SLOT_W'(slot); mask = m; pack6 = p6;
    do_reset();
    run_frames(frames);
  endtask

  initial begin
    config_run(0, 3, 8'hFF, 0, 10);
    config_run(0, 23, 8'hA5, 0, 10);
    config_run(0, 0, 8'h3C, 1, 10);
    config_run(0, 7, 8'h80, 0, 20);
    config_run(0, 12, 8'h01, 1, 14);
    config_run(1, 5, 8'h00, 0, 20);
    config_run(1, 9, 8'hFF, 1, 14);
    config_run(0, 4, 8'h00, 0, 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule